// File: doc/BRIEF.md
# Next Program-Counter Unit

This block holds the program counter of a single-cycle processor and loads it on every rising clock edge. Each cycle it forms three candidate addresses from the present counter and the current instruction word: the next sequential word, a relative branch target and an absolute jump target. Two decode strobes and the ALU equality flag then choose which one is loaded on the next edge.

The counter value goes to instruction fetch. The sequential address is also driven out so that a link-register path can use it. There is no data stream through the block, so every pin is a plain level signal with no valid/ready handshake. The counter cannot be stalled: it has no write enable and no back-pressure.

Top module: `pcu_next_pc`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` loads the parameter `RESET_VECTOR`, which defaults to 0.
- R2: When `jump_en` is low and a branch is not taken, `pc` loads `pc + 4` at the next edge.
- R3: `pc_seq` always equals `pc + 4` (mod 2^32) in the same cycle.
- R4: A taken branch loads `pc + 4 + (sext(instr[15:0]) * 4)`. The 16-bit offset is two's complement, and the sum is formed from the incremented address, not from `pc`.
- R5: A branch is taken only when `branch_en` and `alu_zero` are both high. If either one is low, the result is the sequential path.
- R6: When `jump_en` is high, `pc` loads `{pc_seq[31:28], instr[25:0], 2'b00}`. The top four bits therefore come from the incremented address, so the jump lands in the 256 MB region that holds `pc + 4`.
- R7: `jump_en` overrides the branch path, including when `branch_en` and `alu_zero` are both high.
- R8: All address arithmetic wraps modulo 2^32 and raises no flag. A backward branch past address zero and a sequential step from 0xFFFF_FFFC wrap without any indication.
- R9: Out of reset, the two low bits of `pc` never change from those of `RESET_VECTOR`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter loads on every rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction word being executed this cycle |
| branch_en | input | 1 | Decoded conditional-branch strobe |
| jump_en | input | 1 | Decoded absolute-jump strobe |
| alu_zero | input | 1 | ALU result-is-zero flag |
| pc | output | 32 | Current program counter for fetch |
| pc_seq | output | 32 | Current counter plus four, for linking |

## Verification
The bench sweeps all eight combinations of the three control inputs against many offset patterns, including 0x7FFF, 0x8000 and 0xFFFF. A design that gated the branch on only one of the two conditions, or let a branch beat a jump, would load the wrong address in those cases. Backward offsets catch a sign extension that zero-fills, and a base taken from `pc` instead of `pc + 4` leaves every branch target four bytes short. One jump is taken from 0x0FFF_FFFC, where `pc + 4` has already crossed into the next 256 MB region, so a design that kept the top bits of `pc` would stay in the old region. Wrap cases check that a branch below zero and a step past 0xFFFF_FFFC roll over cleanly.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [1:0] {
    SRC_SEQ    = 2'd0,
    SRC_BRANCH = 2'd1,
    SRC_JUMP   = 2'd2
  } next_src_e;
endpackage

// File: rtl/pcu_incr.sv
module pcu_incr #(
  parameter int ADDR_W = 32,
  parameter int ALIGN  = 2
) (
  input  logic [ADDR_W-1:0] cur,
  output logic [ADDR_W-1:0] nxt
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(1) << ALIGN;
  assign nxt = cur + STEP_V;
endmodule

// File: rtl/pcu_branch_tgt.sv
module pcu_branch_tgt #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int ALIGN  = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] target
);
  localparam int SEXT_W = ADDR_W - OFF_W - ALIGN;
  logic [ADDR_W-1:0] scaled;
  generate
    if (ALIGN > 0) begin : g_shift
      assign scaled = {{SEXT_W{offset[OFF_W-1]}}, offset, {ALIGN{1'b0}}};
    end else begin : g_noshift
      assign scaled = {{SEXT_W{offset[OFF_W-1]}}, offset};
    end
  endgenerate
  assign target = base + scaled;
endmodule

// File: rtl/pcu_jump_tgt.sv
module pcu_jump_tgt #(
  parameter int ADDR_W   = 32,
  parameter int JFIELD_W = 26,
  parameter int ALIGN    = 2
) (
  input  logic [ADDR_W-1:0]   seq_addr,
  input  logic [JFIELD_W-1:0] field,
  output logic [ADDR_W-1:0]   target
);
  localparam int REGION_W = ADDR_W - JFIELD_W - ALIGN;
  generate
    if (ALIGN > 0) begin : g_shift
      assign target = {seq_addr[ADDR_W-1 -: REGION_W], field, {ALIGN{1'b0}}};
    end else begin : g_noshift
      assign target = {seq_addr[ADDR_W-1 -: REGION_W], field};
    end
  endgenerate
endmodule

// File: rtl/pcu_sel.sv
module pcu_sel
  import pcu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              branch_en,
  input  logic              jump_en,
  input  logic              alu_zero,
  input  logic [ADDR_W-1:0] seq_addr,
  input  logic [ADDR_W-1:0] br_addr,
  input  logic [ADDR_W-1:0] jmp_addr,
  output next_src_e         src,
  output logic [ADDR_W-1:0] next_addr
);
  always_comb begin
    if (jump_en)                    src = SRC_JUMP;
    else if (branch_en && alu_zero) src = SRC_BRANCH;
    else                            src = SRC_SEQ;
  end

  always_comb begin
    unique case (src)
      SRC_JUMP:   next_addr = jmp_addr;
      SRC_BRANCH: next_addr = br_addr;
      default:    next_addr = seq_addr;
    endcase
  end
endmodule

// File: rtl/pcu_next_pc.sv
module pcu_next_pc
  import pcu_pkg::*;
#(
  parameter int          ADDR_W       = 32,
  parameter int          INSTR_W      = 32,
  parameter int          OFF_W        = 16,
  parameter int          JFIELD_W     = 26,
  parameter int          ALIGN        = 2,
  parameter logic [31:0] RESET_VECTOR = 32'h0000_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr,
  input  logic               branch_en,
  input  logic               jump_en,
  input  logic               alu_zero,
  output logic [ADDR_W-1:0]  pc,
  output logic [ADDR_W-1:0]  pc_seq
);
  localparam int SEXT_W   = ADDR_W - OFF_W - ALIGN;
  localparam int REGION_W = ADDR_W - JFIELD_W - ALIGN;
  localparam logic [ADDR_W-1:0] RST_V = ADDR_W'(RESET_VECTOR);

  logic [ADDR_W-1:0] br_addr, jmp_addr, next_addr;
  next_src_e         src;
  logic              unused_opcode_bits;

  assign unused_opcode_bits = ^instr[INSTR_W-1:JFIELD_W];

  pcu_incr #(.ADDR_W(ADDR_W), .ALIGN(ALIGN)) u_incr (
    .cur(pc), .nxt(pc_seq)
  );

  pcu_branch_tgt #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .ALIGN(ALIGN)) u_br (
    .base(pc_seq), .offset(instr[OFF_W-1:0]), .target(br_addr)
  );

  pcu_jump_tgt #(.ADDR_W(ADDR_W), .JFIELD_W(JFIELD_W), .ALIGN(ALIGN)) u_jmp (
    .seq_addr(pc_seq), .field(instr[JFIELD_W-1:0]), .target(jmp_addr)
  );

  pcu_sel #(.ADDR_W(ADDR_W)) u_sel (
    .branch_en(branch_en), .jump_en(jump_en), .alu_zero(alu_zero),
    .seq_addr(pc_seq), .br_addr(br_addr), .jmp_addr(jmp_addr),
    .src(src), .next_addr(next_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) pc <= RST_V;
    else     pc <= next_addr;
  end

  assert_reset_load_R1: assert property (@(posedge clk)
    rst |=> pc == RST_V);

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!jump_en && !(branch_en && alu_zero)) |=> pc == $past(pc) + (ADDR_W'(1) << ALIGN));

  // R4 and R5: taken branch lands at incremented address plus scaled offset
  assert_branch_target_R4: assert property (@(posedge clk) disable iff (rst)
    (branch_en && alu_zero && !jump_en) |=>
      pc == $past(pc) + (ADDR_W'(1) << ALIGN)
            + {{SEXT_W{$past(instr[OFF_W-1])}}, $past(instr[OFF_W-1:0]), {ALIGN{1'b0}}});

  // R6 and R7: jump wins and keeps the region of the incremented address
  assert_jump_region_R6: assert property (@(posedge clk) disable iff (rst)
    jump_en |=> pc[ADDR_W-1 -: REGION_W] == $past(pc_seq[ADDR_W-1 -: REGION_W]));

  assert_jump_field_R7: assert property (@(posedge clk) disable iff (rst)
    jump_en |=> pc[ADDR_W-REGION_W-1:0] == {$past(instr[JFIELD_W-1:0]), {ALIGN{1'b0}}});

  assert_aligned_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pc[ALIGN-1:0] == RST_V[ALIGN-1:0]);
endmodule

// File: tb/test_pcu_next_pc.sv
`timescale 1ns/1ps
module test_pcu_next_pc;
  localparam logic [31:0] RV = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic        branch_en = 1'b0, jump_en = 1'b0, alu_zero = 1'b0;
  logic [31:0] pc, pc_seq;

  int n_run = 0, n_fail = 0;
  logic [31:0] exp_pc;

  always #2.5 clk = ~clk;

  pcu_next_pc #(.RESET_VECTOR(RV)) i_pcu_next_pc (
    .clk(clk), .rst(rst), .instr(instr), .branch_en(branch_en),
    .jump_en(jump_en), .alu_zero(alu_zero), .pc(pc), .pc_seq(pc_seq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] p, input logic [31:0] iw,
                                        input logic b, input logic j, input logic z);
    longint unsigned p4;
    longint off;
    p4 = (longint'(p) + 4) % 64'h1_0000_0000;
    if (j) return 32'((p4 & 64'hF000_0000) + longint'(iw & 32'h03FF_FFFF) * 4);
    if (b && z) begin
      off = longint'(iw & 32'hFFFF);
      if (off >= 32768) off = off - 65536;
      return 32'((longint'(p4) + off * 4 + 64'h1_0000_0000) % 64'h1_0000_0000);
    end
    return 32'(p4);
  endfunction

  task automatic step(input logic [31:0] iw, input logic b, input logic j, input logic z);
    string tag;
    instr = iw; branch_en = b; jump_en = j; alu_zero = z;
    #0.5;
    chk("R3", pc_seq, 32'(longint'(pc) + 4));
    exp_pc = model(pc, iw, b, j, z);
    if (j && b && z)  tag = "R7";
    else if (j)       tag = "R6";
    else if (b && z)  tag = "R4";
    else if (b || z)  tag = "R5";
    else              tag = "R2";
    @(negedge clk);
    chk(tag, pc, exp_pc);
    chk("R9", {30'd0, pc[1:0]}, {30'd0, RV[1:0]});
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] offs [8];
    offs[0] = 16'h0000; offs[1] = 16'h0001; offs[2] = 16'h7FFF; offs[3] = 16'h8000;
    offs[4] = 16'hFFFF; offs[5] = 16'hFFC0; offs[6] = 16'h0123; offs[7] = 16'hFF00;
    repeat (2) @(negedge clk);
    chk("R1", pc, RV);
    rst = 1'b0;
    // full control sweep across offset patterns, forward and backward
    for (int o = 0; o < 8; o++) begin
      for (int c = 0; c < 8; c++) begin
        step({6'h04, 10'h155, offs[o]} ^ {6'd0, 26'(o * 32'h0011_0000)},
             c[0], c[1], c[2]);
      end
    end
    for (int k = 0; k < 64; k++) begin
      step({16'hABC0, 16'(k * 1031)}, 1'b1, 1'b0, 1'b1);
    end
    // R6: jump near the 256 MB boundary
    rst = 1'b1; @(negedge clk); chk("R1", pc, RV); rst = 1'b0;
    step({6'h02, 26'h3FF_FFFF}, 1'b0, 1'b1, 1'b0);
    chk("R6", pc, 32'h0FFF_FFFC);
    step({6'h02, 26'h000_0010}, 1'b0, 1'b1, 1'b0);
    chk("R6", pc, 32'h1000_0040);
    // R8: backward branch past zero
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    step({16'h1000, 16'h8000}, 1'b1, 1'b0, 1'b1);
    chk("R8", pc, 32'hFFFE_0104);
    step({6'h02, 26'h3FF_FFFF}, 1'b0, 1'b1, 1'b0);
    chk("R8", pc, 32'hFFFF_FFFC);
    step(32'h0, 1'b0, 1'b0, 1'b0);
    chk("R8", pc, 32'h0000_0000);
    step(32'h0, 1'b1, 1'b1, 1'b1);
    chk("R7", pc, 32'h0000_0000);
    rst = 1'b1; @(negedge clk); chk("R1", pc, RV);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule